// File: doc/BRIEF.md
# Five-Bit XNOR Pseudo-Random Sequence Generator

This block is a five-bit shift register with linear feedback that produces a repeating pseudo-random sequence of register values. On every clock edge the contents move up by one place. A new bit enters at the bottom. That bit is the XNOR of bit positions 5 and 3, with positions numbered 1 (lowest) to 5 (highest). The whole register is visible on one output bus. Other logic can use it as a test pattern source or as a cheap scrambling sequence.

Because the feedback uses XNOR, the all-zeros value is a legal state. The single value the sequence can never leave is all ones (11111). A synchronous, active-high reset clears the register to zero. From zero the register visits 31 distinct values and then repeats. It never reaches 11111.

The output is a plain status-style bus, not a stream. The register advances on every clock, and there is no valid/ready handshake. A consumer therefore cannot apply back-pressure: it samples the value it needs in the cycle it needs it.

Top module: `lfsr_xnor5`

## Requirements
- R1: When `rst` is high at a rising clock edge, `state` is 5'b00000 after that edge. The reset is synchronous.
- R2: Reset takes priority over stepping. While `rst` stays high for several edges, `state` stays 5'b00000, whatever value it held before.
- R3: At each rising edge with `rst` low, the new `state` is formed as follows. Bits [4:1] take the old bits [3:0]. Bit [0] takes the inverse of (old bit [4] XOR old bit [2]). Bit [4] is tap position 5 and bit [2] is tap position 3.
- R4: The first five values seen after reset are 00000, 00001, 00011, 00111 and 01110, in that order.
- R5: Once reset has been applied, `state` never equals 5'b11111.
- R6: Starting from 00000 right after reset, the 31 values seen at steps 0 to 30 are all distinct, and the value at step 31 equals the value at step 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; the register steps on every edge |
| rst | input | 1 | Synchronous active-high reset to all zeros |
| state | output | 5 | Current register contents, bit 4 is tap position 5 |

## Verification
Reset and stepping are the two functions that can fall in the same cycle. When `rst` is high at an edge, the register has to drop the shift it would otherwise take. The bench provokes this by raising `rst` in the middle of the sequence, where the next value would be nonzero, and by holding it across several edges. It judges the result against a behavioural integer model that clears on reset and otherwise computes the next value arithmetically. The bench compares the model with the design after every edge. It then follows a full period after the reset is released, to confirm the sequence restarts at 00000 and runs through its 31 values again.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  localparam int unsigned LFSR_W   = 5;
  localparam int unsigned TAP_HIGH = 5;
  localparam int unsigned TAP_LOW  = 3;

  // Build a feedback tap mask; tap positions are numbered from 1.
  function automatic logic [31:0] tap_mask(input int unsigned hi, input int unsigned lo);
    logic [31:0] m;
    m = '0;
    m[hi-1] = 1'b1;
    m[lo-1] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/lfsr_tap_xnor.sv
module lfsr_tap_xnor #(
  parameter int unsigned WIDTH = 5,
  parameter logic [31:0] MASK  = 32'h14
) (
  input  logic [WIDTH-1:0] cur,
  output logic             fb_bit
);
  logic [WIDTH-1:0] picked;

  // Keep only the tap positions selected by the mask.
  for (genvar i = 0; i < WIDTH; i++) begin : g_pick
    if (MASK[i]) begin : g_on
      assign picked[i] = cur[i];
    end else begin : g_off
      assign picked[i] = 1'b0;
    end
  end

  // XNOR across the selected taps.
  assign fb_bit = ~(^picked);
endmodule

// File: rtl/lfsr_shift_reg.sv
module lfsr_shift_reg #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fb_bit,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q <= {q[WIDTH-2:0], fb_bit};
    end
  end
endmodule

// File: rtl/lfsr_xnor5.sv
module lfsr_xnor5
  import lfsr_pkg::*;
#(
  parameter int unsigned WIDTH  = LFSR_W,
  parameter int unsigned TAP_HI = TAP_HIGH,
  parameter int unsigned TAP_LO = TAP_LOW
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] state
);
  localparam logic [31:0] FB_MASK = tap_mask(TAP_HI, TAP_LO);

  logic             fb_bit;
  logic [WIDTH-1:0] cur;

  lfsr_tap_xnor #(
    .WIDTH (WIDTH),
    .MASK  (FB_MASK)
  ) u_fb (
    .cur    (cur),
    .fb_bit (fb_bit)
  );

  lfsr_shift_reg #(
    .WIDTH (WIDTH)
  ) u_reg (
    .clk    (clk),
    .rst    (rst),
    .fb_bit (fb_bit),
    .q      (cur)
  );

  assign state = cur;
endmodule

// File: rtl/lfsr_xnor5_chk.sv
module lfsr_xnor5_chk #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned TAP_HI = 5,
  parameter int unsigned TAP_LO = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] q
);
  logic armed   = 1'b0;
  logic rst_d   = 1'b0;
  logic stepped = 1'b0;

  always_ff @(posedge clk) begin
    rst_d   <= rst;
    armed   <= armed | rst;
    stepped <= armed & ~rst;
  end

  // A reset seen at the previous edge leaves the register cleared.
  always_ff @(posedge clk) begin
    if (rst_d) begin
      AST_RESET_CLEARS: assert (q == '0); // R1
    end
  end

  AST_STEP_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (armed && stepped) |-> (q[WIDTH-1:1] == $past(q[WIDTH-2:0]))); // R3

  AST_STEP_FEEDBACK: assert property (@(posedge clk) disable iff (rst)
    (armed && stepped) |-> (q[0] == ~($past(q[TAP_HI-1]) ^ $past(q[TAP_LO-1])))); // R3

  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
    armed |-> (q != '1)); // R5

  AST_LEAVE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (armed && q == '0) |=> (q == {{(WIDTH-1){1'b0}}, 1'b1})); // R4
endmodule

bind lfsr_xnor5 lfsr_xnor5_chk #(
  .WIDTH  (WIDTH),
  .TAP_HI (TAP_HI),
  .TAP_LO (TAP_LO)
) u_chk (
  .clk (clk),
  .rst (rst),
  .q   (state)
);

// File: tb/sim_lfsr_xnor5.sv
`timescale 1ns/1ps
module sim_lfsr_xnor5;
  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic [4:0] state;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lfsr_xnor5 u0 (
    .clk   (clk),
    .rst   (rst),
    .state (state)
  );

  function automatic int next_val(input int v);
    int hi;
    int lo;
    hi = (v / 16) % 2;
    lo = (v / 4) % 2;
    return ((v * 2) % 32) + ((hi == lo) ? 1 : 0);
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %05b expected %05b", req, got[4:0], exp[4:0]);
    end
  endtask

  // One clock: drive rst, update model, compare away from the edge (R3 model).
  task automatic tick(input bit r, input string req);
    rst = r;
    @(posedge clk);
    #1;
    model = r ? 0 : next_val(model);
    check(req, int'(state), model);
  endtask

  initial begin
    int seen[$];
    int first;
    #1;
    // R1: reset state
    tick(1'b1, "R1");
    tick(1'b1, "R2");
    // R4: opening values
    check("R4", int'(state), 0);
    tick(1'b0, "R4"); check("R4", int'(state), 5'b00001);
    tick(1'b0, "R4"); check("R4", int'(state), 5'b00011);
    tick(1'b0, "R4"); check("R4", int'(state), 5'b00111);
    tick(1'b0, "R4"); check("R4", int'(state), 5'b01110);
    // R3: run on and compare every clock
    for (int i = 0; i < 9; i++) tick(1'b0, "R3");
    // R1/R2: reset in mid-sequence, where stepping would give nonzero
    check("R2", (state != 0) ? 1 : 0, 1);
    tick(1'b1, "R2");
    tick(1'b1, "R2");
    tick(1'b1, "R2");
    // R6/R5: full period from zero
    first = int'(state);
    check("R6", first, 0);
    seen.push_back(first);
    for (int i = 1; i <= 31; i++) begin
      tick(1'b0, "R3");
      check("R5", (state == 5'b11111) ? 1 : 0, 0);
      if (i < 31) begin
        foreach (seen[k]) if (seen[k] == int'(state)) check("R6", int'(state), -1);
        seen.push_back(int'(state));
      end else begin
        check("R6", int'(state), first);
      end
    end
    check("R6", seen.size(), 31);
    // R2: a single reset cycle right after the zero value
    tick(1'b0, "R3");
    tick(1'b1, "R2");
    tick(1'b0, "R4"); check("R4", int'(state), 5'b00001);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule